// File: doc/BRIEF.md
# I2C Slave Transmitter with Host Handshake

This block is the transmit side of an I2C slave. It watches synchronized copies of SCL and SDA for a START. It shifts in the 8-bit address frame and compares the upper seven bits with a programmed own address. When the address matches and the request is a read, the block acknowledges the frame and sets its transmit-mode flag by itself. It then sends bytes supplied by the host. Between bytes it holds SCL low until the host has serviced it. It samples the acknowledge bit that the master returns after each byte.

The host sees one interrupt flag. The flag is raised at the end of every ninth clock (address or data) and again when a STOP ends an addressed transfer. Transmit bytes enter through a one-entry valid/ready port. `tx_ready` is high only while the holding register is empty. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` is ignored. The block never stalls the host. Instead it stalls the bus: SCL stays low until a byte is waiting and the flag is clear. After the master answers with NACK, the block keeps SCL low until the host pulses `dummy_rd`, which stands for a read of the data register. The host then clears the acknowledge status and the transmit-mode flag, and waits for the STOP.

Top module: `i2cs_tx_slave`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `irq`, `trs` and `ack_seen` are 0 and `tx_ready` is 1.
- R2: A START followed by an address frame whose first seven bits (MSB first) equal `own_addr` and whose eighth bit is 1 (read) makes the block pull SDA low for the whole ninth clock and sets `trs` to 1.
- R3: An address frame with any other address, or with the eighth bit 0, is not acknowledged: SDA stays released on the ninth clock, and `trs` and `irq` stay 0 through the following STOP.
- R4: `irq` goes to 1 at the SCL falling edge that ends each ninth clock of an acknowledged transfer. From that edge SCL is held low while `irq` is 1 or no byte is waiting.
- R5: Each byte is sent MSB first. SDA driven by the block does not change while SCL is high.
- R6: The block releases SDA during the master's acknowledge clock after each data byte.
- R7: `ack_seen` takes the SDA level the master drives on the acknowledge clock (0 = ACK). After an ACK, the next byte goes out once the host has serviced the flag.
- R8: After a NACK (`ack_seen` = 1), SCL stays low after the acknowledge clock until `dummy_rd` is pulsed, whether or not `irq` has been cleared.
- R9: A STOP seen after an acknowledged read address sets `irq` to 1.
- R10: A byte is accepted on a cycle with `tx_valid` and `tx_ready` both 1. `tx_ready` stays 0 while an accepted byte has not yet started shifting, and a byte offered during that time is dropped and never sent.
- R11: `irq_clr`, `ack_clr` and `trs_clr` each clear their flag to 0. A flag set by the block in the same cycle wins.
- R12: A START at any point restarts address reception from the first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Programmed 7-bit slave address |
| tx_valid | input | 1 | Host offers a transmit byte |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 8 | Transmit byte |
| irq | output | 1 | Interrupt flag |
| irq_clr | input | 1 | Pulse clears `irq` |
| ack_seen | output | 1 | Last acknowledge bit sampled from the master |
| ack_clr | input | 1 | Pulse clears `ack_seen` |
| trs | output | 1 | Transmit-mode flag |
| trs_clr | input | 1 | Pulse clears `trs` (back to receive mode) |
| dummy_rd | input | 1 | Data-register read pulse; releases SCL after a NACK |

## Verification
The bench sweeps all 256 address-frame values. Only the single read of the own address may be acknowledged. A comparator that is off by one bit, or that ignores the direction bit, would either ACK a neighbouring address or raise `trs` on a write. The bench then sends all 256 byte values in one transfer. A shift register that ran LSB first or shifted on the wrong edge would corrupt the bytes, and a block that drove SDA into the acknowledge clock would hide the master's ACK. The bench also covers the stall cases. If the stretch released on a cleared flag with no byte waiting, it would clock out stale data. If it released after a NACK without the dummy read, the host would lose its window. A byte offered while the holding register is full must not overwrite the first byte. A repeated START in the middle of a frame must realign address reception, or the block would acknowledge a shifted address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // not addressed
    ST_ADDR,   // shifting in the address frame
    ST_AACK,   // driving the address acknowledge
    ST_WAIT,   // stretching SCL until serviced
    ST_BIT,    // shifting a data byte out
    ST_MACK,   // master's acknowledge clock
    ST_END,    // after NACK, stretching until dummy read
    ST_STOPW   // released, waiting for STOP
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  // one flop per stage; the bus idles high so every stage resets to 1
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_q[g] <= 1'b1;
        sda_q[g] <= 1'b1;
      end else begin
        scl_q[g] <= (g == 0) ? scl_i : scl_q[(g == 0) ? 0 : g-1];
        sda_q[g] <= (g == 0) ? sda_i : sda_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_txbuf.sv
module i2cs_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
    end else if (in_valid && in_ready) begin
      full     <= 1'b1;
      out_data <= in_data;
    end else if (take) begin
      full     <= 1'b0;
    end
  end

  assign in_ready = ~full;
endmodule

// File: rtl/i2cs_tx_slave.sv
module i2cs_tx_slave
  import i2cs_pkg::*;
#(
  parameter int AW     = 7,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [AW-1:0] own_addr,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          irq,
  input  logic          irq_clr,
  output logic          ack_seen,
  input  logic          ack_clr,
  output logic          trs,
  input  logic          trs_clr,
  input  logic          dummy_rd
);
  localparam int FW   = AW + 1;
  localparam int MAXB = (FW > DW) ? FW : DW;
  localparam int CW   = $clog2(MAXB + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic buf_full, take, hold_q, nack_q, at_end;
  logic [DW-1:0] buf_data, tx_sr;
  logic [FW-1:0] rx_sr;
  logic [CW-1:0] cnt;
  i2cs_state_e   state;

  i2cs_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_txbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .take(take), .full(buf_full), .out_data(buf_data)
  );

  assign take = (state == ST_WAIT) && !irq && buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      irq      <= 1'b0;
      ack_seen <= 1'b0;
      trs      <= 1'b0;
      hold_q   <= 1'b0;
      nack_q   <= 1'b0;
    end else begin
      hold_q <= 1'b0;
      // host clears first so that a set in the same cycle takes priority
      if (irq_clr) irq      <= 1'b0;
      if (ack_clr) ack_seen <= 1'b0;
      if (trs_clr) trs      <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        if (state != ST_IDLE && state != ST_ADDR) irq <= 1'b1;
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sr <= {rx_sr[FW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(FW)) begin
              if (rx_sr[FW-1:1] == own_addr && rx_sr[0]) begin
                state <= ST_AACK;
                trs   <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            irq   <= 1'b1;
            state <= ST_WAIT;
          end
          ST_WAIT: if (take) begin
            tx_sr  <= buf_data;
            cnt    <= '0;
            hold_q <= 1'b1;   // one extra cycle of SDA setup before SCL is let go
            state  <= ST_BIT;
          end
          ST_BIT: if (scl_fall) begin
            if (cnt == CW'(DW - 1)) begin
              state <= ST_MACK;
            end else begin
              tx_sr <= {tx_sr[DW-2:0], 1'b0};
              cnt   <= cnt + 1'b1;
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              ack_seen <= sda_s;
              nack_q   <= sda_s;
            end else if (scl_fall) begin
              irq   <= 1'b1;
              state <= nack_q ? ST_END : ST_WAIT;
            end
          end
          ST_END: if (dummy_rd) state <= ST_STOPW;
          default: ;
        endcase
      end
    end
  end

  assign at_end = (state == ST_END);
  assign scl_oe = (state == ST_WAIT) || at_end || hold_q;
  assign sda_oe = (state == ST_AACK) || ((state == ST_BIT) && !tx_sr[DW-1]);
endmodule

// File: rtl/i2cs_tx_checks.sv
module i2cs_tx_checks (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic trs,
  input logic tx_ready,
  input logic take,
  input logic dummy_rd,
  input logic at_end
);
  // R5: the slave's SDA drive is frozen while synchronized SCL stays high
  p_sda_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R4: a stretch ends only once the flag is clear, unless it is the dummy-read release
  p_release_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && !$past(dummy_rd)) |-> !$past(irq));

  // R2: transmit mode is entered together with the address acknowledge
  p_trs_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trs) |-> sda_oe);

  // R8: after a NACK, SCL stays low until the dummy read
  p_nack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !dummy_rd) |=> scl_oe);

  // R10: the holding register stays full until the FSM takes the byte
  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !take) |=> !tx_ready);
endmodule

bind i2cs_tx_slave i2cs_tx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .trs(trs), .tx_ready(tx_ready), .take(take),
  .dummy_rd(dummy_rd), .at_end(at_end)
);

// File: tb/sim_i2cs_tx_slave.sv
module sim_i2cs_tx_slave;
  localparam int Q = 4;
  localparam logic [6:0] OWN = 7'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe, tx_ready, irq, ack_seen, trs;
  logic tx_valid = 1'b0, irq_clr = 1'b0, ack_clr = 1'b0, trs_clr = 1'b0, dummy_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic last_oe;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2cs_tx_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .irq(irq), .irq_clr(irq_clr), .ack_seen(ack_seen), .ack_clr(ack_clr),
    .trs(trs), .trs_clr(trs_clr), .dummy_rd(dummy_rd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_scl_high();
    while (!scl_line) wait_cyc(1);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_scl_high(); wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b1; wait_scl_high(); wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic m_bit(input logic b, output logic s1, output logic s2);
    sda_m = b; wait_cyc(Q);
    scl_m = 1'b1; wait_scl_high(); wait_cyc(Q);
    s1 = sda_line; last_oe = sda_oe;
    wait_cyc(Q);
    s2 = sda_line;
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic m_addr(input logic [6:0] a, input logic rw, output logic acked);
    logic s1, s2;
    logic [7:0] fr;
    fr = {a, rw};
    for (int i = 7; i >= 0; i--) m_bit(fr[i], s1, s2);
    m_bit(1'b1, s1, s2);
    acked = !s1;
  endtask

  task automatic m_read(input logic mnack, output logic [7:0] d, output int unstable, output logic oe_ack);
    logic s1, s2;
    unstable = 0;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, s1, s2);
      d = {d[6:0], s1};
      if (s1 !== s2) unstable++;
    end
    m_bit(mnack, s1, s2);
    oe_ack = last_oe;
  endtask

  task automatic push(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1; wait_cyc(1); tx_valid = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1; wait_cyc(1); irq_clr = 1'b0;
  endtask

  task automatic read_and_check(input logic [7:0] exp, input logic mnack);
    logic [7:0] d;
    int unst;
    logic oe;
    m_read(mnack, d, unst, oe);
    check("R5", "byte MSB first", d, exp);
    check("R5", "SDA stable while SCL high", unst, 0);
    check("R6", "SDA released on ack clock", oe, 0);
    wait_cyc(2);
    check("R4", "irq after byte", irq, 1);
    check("R4", "SCL held after byte", scl_oe, 1);
    check("R7", "ack_seen holds master ack", ack_seen, mnack);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic acked;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    check("R1", "scl_oe", scl_oe, 0);
    check("R1", "sda_oe", sda_oe, 0);
    check("R1", "irq", irq, 0);
    check("R1", "trs", trs, 0);
    check("R1", "ack_seen", ack_seen, 0);
    check("R1", "tx_ready", tx_ready, 1);

    // R3 sweep of every address and direction except the own read
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        if (a == int'(OWN) && rw == 1) continue;
        m_start();
        m_addr(7'(a), 1'(rw), acked);
        check("R3", "no ack for other frame", acked, 0);
        m_stop();
        wait_cyc(3);
        check("R3", "irq and trs stay low", {30'd0, irq, trs}, 0);
      end
    end

    // R2 read of own address
    m_start();
    m_addr(OWN, 1'b1, acked);
    wait_cyc(2);
    check("R2", "own read acked", acked, 1);
    check("R2", "trs set", trs, 1);
    check("R4", "irq after address", irq, 1);
    check("R4", "SCL held after address", scl_oe, 1);
    // R4 flag cleared but no byte waiting: still stretching
    clr_irq();
    wait_cyc(12);
    check("R4", "SCL held with empty buffer", scl_oe, 1);
    push(8'h96);
    wait_cyc(4);
    check("R4", "SCL released once serviced", scl_oe, 0);
    read_and_check(8'h96, 1'b0);

    // R5 R7 sweep of every byte value in one transfer, NACK on the last
    for (int i = 0; i < 256; i++) begin
      push(8'(i));
      if (i == 0) begin
        check("R10", "tx_ready low while byte waits", tx_ready, 0);
        push(8'hFF);                       // offered while not ready: dropped
        wait_cyc(6);
        check("R4", "SCL held while irq set", scl_oe, 1);
      end
      clr_irq();
      read_and_check(8'(i), (i == 255));
    end

    // R8 NACK ending
    clr_irq();
    wait_cyc(12);
    check("R8", "SCL held after NACK with irq clear", scl_oe, 1);
    ack_clr = 1'b1; wait_cyc(1); ack_clr = 1'b0;
    check("R11", "ack_clr", ack_seen, 0);
    trs_clr = 1'b1; wait_cyc(1); trs_clr = 1'b0;
    check("R11", "trs_clr", trs, 0);
    dummy_rd = 1'b1; wait_cyc(1); dummy_rd = 1'b0;
    wait_cyc(2);
    check("R8", "SCL released by dummy read", scl_oe, 0);
    m_stop();
    wait_cyc(3);
    check("R9", "irq on STOP", irq, 1);
    clr_irq();
    check("R11", "irq_clr", irq, 0);

    // R12 repeated START inside an address frame
    m_start();
    begin
      logic s1, s2;
      for (int i = 0; i < 4; i++) m_bit(1'b1, s1, s2);
    end
    m_start();
    m_addr(OWN, 1'b1, acked);
    wait_cyc(2);
    check("R12", "ack after repeated START", acked, 1);
    push(8'hC3);
    clr_irq();
    read_and_check(8'hC3, 1'b1);
    clr_irq();
    dummy_rd = 1'b1; wait_cyc(1); dummy_rd = 1'b0;
    m_stop();
    wait_cyc(3);
    check("R9", "irq on second STOP", irq, 1);
    clr_irq();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule